// File: doc/BRIEF.md
# I2C Target Receive DMA Engine

This block is the receive half of an I2C target operating in packet mode. It does not work at the wire level. A bus front end hands it one event per completed bus item: a start condition, an address byte, a data byte, or a stop condition. When the address byte names the programmed own address with the write direction, the engine opens a transfer. It then streams each data byte into memory through a byte-wide DMA write port with a valid/ready handshake. Per accepted beat it advances the address counter, shrinks the remaining-space counter and grows a live received-length count.

Firmware sets the block up through a small register port before any traffic arrives. It enables target mode alongside controller mode, writes the address to answer, enables receive DMA, and loads the buffer base and length. When a stop closes an accepted transfer, four completion flags are set in a status register. A single status write can wipe the low flags in one go. The interrupt line is shared with an external controller-side request, and an arbiter gives it to one source at a time. A source that is waiting gets the line as soon as the current owner's status clears.

Top module: `i2c_tgt_rx_dma`

## Requirements
- R1: Register 0 holds two independent enables, target (bit 0) and controller (bit 1), and both may be set together. With the target enable clear, no transfer is accepted.
- R2: An address byte opens a transfer only if bits 7:1 equal the own address in register 1 and bit 0 is 0 (write). Data bytes seen outside an open transfer produce no DMA beat and no length change.
- R3: No transfer is accepted unless receive DMA is enabled by bit 0 of register 2.
- R4: A start event resets the received length (read at register 5) to zero.
- R5: Each accepted DMA beat carries the next data byte in arrival order. After the beat, the address counter (read at register 3, loaded by writing it) has gone up by one, the remaining length (register 4) has gone down by one, and the received length has gone up by one.
- R6: A stop that closes an open transfer sets status bits 0 (packet done), 1 (address matched), 2 (stop seen) and 3 (receive direction). The status register is register 6.
- R7: A status write with bit 16 set clears status bits 7:0 at once and leaves bit 8 unchanged. A one written to any of bits 8:0 clears that bit alone.
- R8: A write to register 4 loads the remaining length from bits 15:0 only when bit 31 of the written value is 1. Otherwise it leaves it unchanged.
- R9: The shared interrupt goes to one source at a time. While the controller request owns it, target status stays pending and `irq_tgt` stays low. When the owner's request clears and the other is pending, the line passes to the other. The same holds in the reverse direction.
- R10: When the remaining length is zero, further data bytes create no beat and move no counter, and status bit 8 (overflow) is set.
- R11: While `dma_valid` is high and `dma_ready` is low, the beat's address and data hold steady. The counters step only on an accepted beat.
- R12: A status bit requests the interrupt only when the same bit of the enable register (register 7) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Registered read value of the register at reg_addr |
| ev_valid | input | 1 | Bus event present |
| ev_kind | input | 2 | 0 start, 1 address, 2 data, 3 stop |
| ev_byte | input | 8 | Byte carried by address or data events |
| ev_ready | output | 1 | Event accepted this cycle when high |
| dma_valid | output | 1 | DMA beat pending |
| dma_addr | output | AW | Beat address, also the live address counter |
| dma_data | output | 8 | Beat data byte |
| dma_ready | input | 1 | Memory accepts the beat |
| ctl_irq_req | input | 1 | Controller-side interrupt request |
| irq | output | 1 | Shared interrupt line |
| irq_tgt | output | 1 | High when the target side owns the line |

## Verification
The assertions take two things for granted. First, firmware leaves the base address and length registers alone while a transfer is open. Second, the front end holds each event steady until `ev_ready` takes it. The bench programs the registers only between transfers and presents events through one task that waits for acceptance. The memory side is left free: `dma_ready` is either held high or pulsed one cycle in three. This is how the hold rule on a stalled beat gets exercised.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [1:0] {EV_START = 2'd0, EV_ADDR = 2'd1, EV_DATA = 2'd2, EV_STOP = 2'd3} ev_kind_e;
  typedef enum logic [1:0] {OWN_NONE = 2'd0, OWN_CTL = 2'd1, OWN_TGT = 2'd2} irq_owner_e;

  localparam logic [2:0] REG_FUNC  = 3'd0;
  localparam logic [2:0] REG_OWN   = 3'd1;
  localparam logic [2:0] REG_CMD   = 3'd2;
  localparam logic [2:0] REG_BASE  = 3'd3;
  localparam logic [2:0] REG_LEN   = 3'd4;
  localparam logic [2:0] REG_RXLEN = 3'd5;
  localparam logic [2:0] REG_STAT  = 3'd6;
  localparam logic [2:0] REG_IER   = 3'd7;

  localparam int ST_W        = 9;   // status width
  localparam int ST_KEEP     = 8;   // bits at and above this survive a clear-all
  localparam int ST_DROP     = 8;
  localparam int CLR_ALL_BIT = 16;
  localparam int LEN_WE_BIT  = 31;
endpackage

// File: rtl/tgt_rx_engine.sv
module tgt_rx_engine
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_valid,
  input  logic [1:0]    ev_kind,
  input  logic [7:0]    ev_byte,
  output logic          ev_ready,
  input  logic          tgt_en,
  input  logic          rx_en,
  input  logic [6:0]    own_addr,
  input  logic          ld_base,
  input  logic [AW-1:0] base_val,
  input  logic          ld_len,
  input  logic [LW-1:0] len_val,
  output logic          dma_valid,
  output logic [AW-1:0] dma_addr,
  output logic [7:0]    dma_data,
  input  logic          dma_ready,
  output logic [LW-1:0] remain,
  output logic [LW-1:0] rx_len,
  output logic          done_pulse,
  output logic          drop_pulse
);
  logic active, take, beat;
  ev_kind_e kind;

  assign kind     = ev_kind_e'(ev_kind);
  assign ev_ready = !dma_valid;
  assign take     = ev_valid && ev_ready;
  assign beat     = dma_valid && dma_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      dma_valid  <= 1'b0;
      dma_addr   <= '0;
      dma_data   <= '0;
      remain     <= '0;
      rx_len     <= '0;
      done_pulse <= 1'b0;
      drop_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      drop_pulse <= 1'b0;
      if (ld_base) dma_addr <= base_val;
      else if (beat) dma_addr <= dma_addr + AW'(1);
      if (ld_len) remain <= len_val;
      else if (beat) remain <= remain - LW'(1);
      if (beat) begin
        dma_valid <= 1'b0;
        rx_len    <= rx_len + LW'(1);
      end
      if (take) begin
        case (kind)
          EV_START: begin
            active <= 1'b0;
            rx_len <= '0;
          end
          EV_ADDR: active <= tgt_en && rx_en && (ev_byte[7:1] == own_addr) && !ev_byte[0];
          EV_DATA: begin
            if (active) begin
              if (remain != '0) begin
                dma_valid <= 1'b1;
                dma_data  <= ev_byte;
              end else begin
                drop_pulse <= 1'b1;
              end
            end
          end
          default: begin
            done_pulse <= active;
            active     <= 1'b0;
          end
        endcase
      end
    end
  end

  p_rxlen_clear_r4: assert property (@(posedge clk) disable iff (rst)
    take && kind == EV_START |=> rx_len == '0);
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    beat && !ld_base && !ld_len |=> dma_addr == $past(dma_addr) + AW'(1) && remain == $past(remain) - LW'(1));
  p_no_beat_empty_r10: assert property (@(posedge clk) disable iff (rst)
    dma_valid |-> remain != '0);
  p_hold_stall_r11: assert property (@(posedge clk) disable iff (rst)
    dma_valid && !dma_ready && !ld_base |=> dma_valid && $stable(dma_addr) && $stable(dma_data));
  p_closed_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !active && !dma_valid |=> !$rose(dma_valid));
endmodule

// File: rtl/tgt_status.sv
module tgt_status
  import i2c_tgt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [ST_W-1:0] w1c_bits,
  input  logic            clr_all,
  input  logic            done_pulse,
  input  logic            drop_pulse,
  input  logic [ST_W-1:0] ier,
  output logic [ST_W-1:0] status,
  output logic            tgt_req
);
  localparam logic [ST_W-1:0] LOW_MASK = ST_W'((1 << ST_KEEP) - 1);
  logic [ST_W-1:0] clr, set;

  always_comb begin
    clr = '0;
    if (wr) clr = w1c_bits | (clr_all ? LOW_MASK : '0);
    set = '0;
    if (done_pulse) set[3:0] = 4'hF;
    if (drop_pulse) set[ST_DROP] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr) | set;
  end

  assign tgt_req = |(status & ier);

  p_clear_all_r7: assert property (@(posedge clk) disable iff (rst)
    wr && clr_all && !done_pulse |=> status[ST_KEEP-1:0] == '0);
  p_keep_high_r7: assert property (@(posedge clk) disable iff (rst)
    wr && clr_all && !w1c_bits[ST_DROP] && !drop_pulse |=> status[ST_DROP] == $past(status[ST_DROP]));
  p_done_flags_r6: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> status[3:0] == 4'hF);
endmodule

// File: rtl/irq_share.sv
module irq_share
  import i2c_tgt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ctl_req,
  input  logic tgt_req,
  output logic irq,
  output logic irq_tgt
);
  irq_owner_e owner;

  always_ff @(posedge clk) begin
    if (rst) owner <= OWN_NONE;
    else begin
      case (owner)
        OWN_CTL: if (!ctl_req) owner <= tgt_req ? OWN_TGT : OWN_NONE;
        OWN_TGT: if (!tgt_req) owner <= ctl_req ? OWN_CTL : OWN_NONE;
        default: begin
          if (ctl_req)      owner <= OWN_CTL;
          else if (tgt_req) owner <= OWN_TGT;
        end
      endcase
    end
  end

  assign irq     = owner != OWN_NONE;
  assign irq_tgt = owner == OWN_TGT;

  p_ctl_holds_r9: assert property (@(posedge clk) disable iff (rst)
    irq && !irq_tgt && ctl_req |=> irq && !irq_tgt);
  p_tgt_holds_r9: assert property (@(posedge clk) disable iff (rst)
    irq_tgt && tgt_req |=> irq_tgt);
  p_handover_r9: assert property (@(posedge clk) disable iff (rst)
    irq && !irq_tgt && !ctl_req && tgt_req |=> irq_tgt);
endmodule

// File: rtl/i2c_tgt_rx_dma.sv
module i2c_tgt_rx_dma
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ev_valid,
  input  logic [1:0]    ev_kind,
  input  logic [7:0]    ev_byte,
  output logic          ev_ready,
  output logic          dma_valid,
  output logic [AW-1:0] dma_addr,
  output logic [7:0]    dma_data,
  input  logic          dma_ready,
  input  logic          ctl_irq_req,
  output logic          irq,
  output logic          irq_tgt
);
  logic [1:0]      func_q;
  logic [6:0]      own_q;
  logic            rxen_q;
  logic [ST_W-1:0] ier_q, status;
  logic [LW-1:0]   remain, rx_len;
  logic            done_pulse, drop_pulse, tgt_req;
  logic            ld_base, ld_len, st_wr;

  assign ld_base = reg_we && reg_addr == REG_BASE;
  assign ld_len  = reg_we && reg_addr == REG_LEN && reg_wdata[LEN_WE_BIT];
  assign st_wr   = reg_we && reg_addr == REG_STAT;

  always_ff @(posedge clk) begin
    if (rst) begin
      func_q <= '0;
      own_q  <= '0;
      rxen_q <= 1'b0;
      ier_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        REG_FUNC: func_q <= reg_wdata[1:0];
        REG_OWN:  own_q  <= reg_wdata[6:0];
        REG_CMD:  rxen_q <= reg_wdata[0];
        REG_IER:  ier_q  <= reg_wdata[ST_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        REG_FUNC:  reg_rdata <= 32'(func_q);
        REG_OWN:   reg_rdata <= 32'(own_q);
        REG_CMD:   reg_rdata <= 32'(rxen_q);
        REG_BASE:  reg_rdata <= 32'(dma_addr);
        REG_LEN:   reg_rdata <= 32'(remain);
        REG_RXLEN: reg_rdata <= 32'(rx_len);
        REG_STAT:  reg_rdata <= 32'(status);
        default:   reg_rdata <= 32'(ier_q);
      endcase
    end
  end

  tgt_rx_engine #(.AW(AW), .LW(LW)) u_eng (
    .clk(clk), .rst(rst),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte), .ev_ready(ev_ready),
    .tgt_en(func_q[0]), .rx_en(rxen_q), .own_addr(own_q),
    .ld_base(ld_base), .base_val(reg_wdata[AW-1:0]),
    .ld_len(ld_len), .len_val(reg_wdata[LW-1:0]),
    .dma_valid(dma_valid), .dma_addr(dma_addr), .dma_data(dma_data), .dma_ready(dma_ready),
    .remain(remain), .rx_len(rx_len),
    .done_pulse(done_pulse), .drop_pulse(drop_pulse)
  );

  tgt_status u_st (
    .clk(clk), .rst(rst),
    .wr(st_wr), .w1c_bits(reg_wdata[ST_W-1:0]), .clr_all(reg_wdata[CLR_ALL_BIT]),
    .done_pulse(done_pulse), .drop_pulse(drop_pulse),
    .ier(ier_q), .status(status), .tgt_req(tgt_req)
  );

  irq_share u_irq (
    .clk(clk), .rst(rst),
    .ctl_req(ctl_irq_req), .tgt_req(tgt_req),
    .irq(irq), .irq_tgt(irq_tgt)
  );

  p_len_we_r8: assert property (@(posedge clk) disable iff (rst)
    reg_we && reg_addr == REG_LEN && !reg_wdata[LEN_WE_BIT] && !(dma_valid && dma_ready) |=> $stable(remain));
  p_ier_gate_r12: assert property (@(posedge clk) disable iff (rst)
    ier_q == '0 |-> !tgt_req);
endmodule

// File: tb/tb_i2c_tgt_rx_dma.sv
module tb_i2c_tgt_rx_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_valid = 1'b0;
  logic [1:0]  ev_kind = '0;
  logic [7:0]  ev_byte = '0;
  logic        ev_ready;
  logic        dma_valid;
  logic [31:0] dma_addr;
  logic [7:0]  dma_data;
  logic        dma_ready = 1'b1;
  logic        ctl_irq_req = 1'b0;
  logic        irq, irq_tgt;

  int nvec = 0, nerr = 0, nb = 0, cyc = 0, rmode = 0;
  logic [31:0] cap_addr [0:15];
  logic [7:0]  cap_data [0:15];
  bit done = 0;
  localparam logic [6:0] OWN = 7'h2C;

  always #10 clk = ~clk;

  i2c_tgt_rx_dma dut (.*);

  always @(negedge clk) begin
    cyc = cyc + 1;
    dma_ready = (rmode == 0) ? 1'b1 : (cyc % 3 == 0);
    #1;
    if (!rst && dma_valid && dma_ready && nb < 16) begin
      cap_addr[nb] = dma_addr;
      cap_data[nb] = dma_data;
      nb = nb + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic ev(input logic [1:0] k, input logic [7:0] b);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] abyte, input int n, input int seed);
    ev(2'd0, 8'h00);
    ev(2'd1, abyte);
    for (int k = 0; k < n; k++) ev(2'd2, 8'(seed * 16 + k));
    ev(2'd3, 8'h00);
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] base, input int len);
    wr(3'd6, 32'h1FF);
    wr(3'd3, base);
    wr(3'd4, 32'h8000_0000 | 32'(len));
    nb = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int it;
    it = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    rd(3'd6, v); chk("R6 reset status", v, 32'h0);
    rd(3'd5, v); chk("R4 reset rxlen", v, 32'h0);
    chk("R9 reset irq", {31'b0, irq}, 32'h0);
    chk("R11 reset dma_valid", {31'b0, dma_valid}, 32'h0);

    // R1: both enables together
    wr(3'd0, 32'h3);
    rd(3'd0, v); chk("R1 func both", v, 32'h3);
    wr(3'd1, 32'(OWN));
    wr(3'd2, 32'h1);

    // R5 R10 R11 R6 sweep
    for (int rm = 0; rm < 2; rm++) begin
      for (int len = 0; len <= 4; len++) begin
        for (int n = 0; n <= 5; n++) begin
          int exp_b;
          logic [31:0] base;
          bit ok;
          rmode = rm;
          base = 32'h0000_1000 + 32'(it * 32);
          exp_b = (n < len) ? n : len;
          setup(base, len);
          xfer({OWN, 1'b0}, n, it);
          ok = (nb == exp_b);
          for (int k = 0; k < exp_b && k < 16; k++)
            if (cap_addr[k] !== base + 32'(k) || cap_data[k] !== 8'(it * 16 + k)) ok = 0;
          chk("R5 R11 beat sequence", {31'b0, ok}, 32'h1);
          rd(3'd3, v); chk("R5 addr counter", v, base + 32'(exp_b));
          rd(3'd4, v); chk("R5 remaining", v, 32'(len - exp_b));
          rd(3'd5, v); chk("R5 rxlen", v, 32'(exp_b));
          rd(3'd6, v); chk("R6 R10 status", v, 32'h00F | ((n > len) ? 32'h100 : 32'h0));
          it++;
        end
      end
    end
    rmode = 0;

    // R7: clear-all keeps bit 8
    setup(32'h2000, 1);
    xfer({OWN, 1'b0}, 3, 1);
    rd(3'd6, v); chk("R10 drop flag", v, 32'h10F);
    wr(3'd6, 32'h0001_0000);
    rd(3'd6, v); chk("R7 clear-all keeps bit8", v, 32'h100);
    wr(3'd6, 32'h100);
    rd(3'd6, v); chk("R7 single w1c", v, 32'h0);

    // R8: length write without enable bit
    wr(3'd4, 32'h8000_0005);
    wr(3'd4, 32'h0000_0009);
    rd(3'd4, v); chk("R8 no write enable", v, 32'h5);
    wr(3'd4, 32'h8000_0002);
    rd(3'd4, v); chk("R8 write enable", v, 32'h2);

    // R4: start alone clears rxlen
    setup(32'h3000, 4);
    xfer({OWN, 1'b0}, 2, 2);
    rd(3'd5, v); chk("R4 rxlen before", v, 32'h2);
    ev(2'd0, 8'h00);
    rd(3'd5, v); chk("R4 rxlen after start", v, 32'h0);

    // R2: wrong address and read direction
    setup(32'h4000, 4);
    xfer({OWN ^ 7'h01, 1'b0}, 3, 3);
    chk("R2 wrong addr beats", 32'(nb), 32'h0);
    rd(3'd5, v); chk("R2 wrong addr rxlen", v, 32'h0);
    rd(3'd6, v); chk("R2 wrong addr status", v, 32'h0);
    xfer({OWN, 1'b1}, 3, 3);
    chk("R2 read dir beats", 32'(nb), 32'h0);
    rd(3'd4, v); chk("R2 read dir remaining", v, 32'h4);

    // R3: rx dma disabled
    wr(3'd2, 32'h0);
    xfer({OWN, 1'b0}, 2, 4);
    chk("R3 disabled beats", 32'(nb), 32'h0);
    rd(3'd6, v); chk("R3 disabled status", v, 32'h0);
    wr(3'd2, 32'h1);

    // R1: target enable off
    wr(3'd0, 32'h2);
    xfer({OWN, 1'b0}, 2, 5);
    chk("R1 target off beats", 32'(nb), 32'h0);
    wr(3'd0, 32'h3);

    // R12: enable gating
    setup(32'h5000, 4);
    xfer({OWN, 1'b0}, 1, 6);
    chk("R12 masked irq", {31'b0, irq}, 32'h0);
    wr(3'd7, 32'h1);
    repeat (2) @(negedge clk);
    chk("R12 unmasked irq_tgt", {30'b0, irq, irq_tgt}, 32'h3);
    wr(3'd6, 32'h1FF);
    repeat (2) @(negedge clk);
    chk("R12 cleared irq", {31'b0, irq}, 32'h0);

    // R9: controller first, then target waits
    ctl_irq_req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 ctl owns", {30'b0, irq, irq_tgt}, 32'h2);
    setup(32'h6000, 4);
    xfer({OWN, 1'b0}, 1, 7);
    chk("R9 tgt pending", {30'b0, irq, irq_tgt}, 32'h2);
    ctl_irq_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 tgt raised after ctl clears", {30'b0, irq, irq_tgt}, 32'h3);
    ctl_irq_req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 tgt keeps line", {30'b0, irq, irq_tgt}, 32'h3);
    wr(3'd6, 32'h1FF);
    repeat (2) @(negedge clk);
    chk("R9 ctl raised after tgt clears", {30'b0, irq, irq_tgt}, 32'h2);
    ctl_irq_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 line idle", {31'b0, irq}, 32'h0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule